// File: doc/BRIEF.md
# Triggered Pulse Burst Generator

This block emits a finite train of square pulses on a single output pin each time software asks for one. A power-of-two prescaler divides the source clock by 2^x. Each pulse is high for 2^x source cycles and then low for 2^x cycles, so the pulse rate is the source clock divided by 2^(x+1). Software programs the divide exponent x and a burst length y, then writes a start bit. The block sends exactly y pulses, holds the output low afterwards, and reports through a read-only busy bit whether a burst is still running.

A force-high control drives the output high over every other control, which lets the pin serve as a plain output. An enable bit gates the burst machinery. A power-save input stops any burst in progress. All registers are reached through a small synchronous write port and a combinational read port.

Top module: `burst_pulse_gen`

## Requirements
- R1: After reset every register reads 0, `pulseOut` is low and the busy bit is 0.
- R2: Register map. Address 0 is control: bit0 enable (R/W), bit1 start (write 1 to launch), bit2 busy (read-only; writes are ignored), bit3 force-high (R/W), bits 7:4 read 0. Address 1 holds the divide exponent x in bits 3:0. Address 2 holds the 8-bit burst length y. Address 3 reads 0. `rdData` follows `addr` combinationally.
- R3: A control write with start=1 and enable=1, made while idle, with power save low and y≠0, sets busy and drives `pulseOut` high on the clock edge that takes the write.
- R4: During a burst each pulse is high for exactly 2^x cycles and then low for 2^x cycles, and exactly y pulses are produced.
- R5: At the edge that ends the last pulse's high phase, `pulseOut` goes low and busy clears on that same edge. The output then stays low until the next accepted start.
- R6: A start with y = 0 produces no pulse and leaves busy at 0.
- R7: A start write that arrives while a burst is running neither restarts nor lengthens that burst.
- R8: The start bit is self-clearing and always reads back as 0.
- R9: While force-high is 1, `pulseOut` is high regardless of enable, burst state or power save.
- R10: A start whose write carries enable=0 is ignored. A control write that clears enable during a burst ends the burst: busy clears and the output goes low at that edge.
- R11: While `powerSave` is high, `pulseOut` is low at once unless force-high is set, a running burst is aborted with busy clear by the next edge, and start writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for `addr` |
| powerSave | input | 1 | Power-save request |
| pulseOut | output | 1 | Burst output pin |

## Verification
The bench measures every high and low phase cycle by cycle against a schedule built from x and y. A prescaler that is off by one would stretch or shorten each phase, and a pulse counter that is off by one would add or drop a final pulse. It tests x = 0, where the output must toggle on every clock; a design that loads its prescaler wrongly stalls or doubles there. It also tests y = 0, which a naive down-counter would wrap into 256 pulses. A second start is written in the middle of a burst, where a design that reloads its counter would show extra pulses. Power save and a cleared enable are applied mid-pulse, where a design that only stops its prescaler would leave the pin stuck high.

// File: rtl/burst_pulse_pkg.sv
package burst_pulse_pkg;
  localparam int DATA_W = 8;
  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_DIV  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_LEN  = 2'd2;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_START = 1;
  localparam int CTRL_BUSY  = 2;
  localparam int CTRL_FORCE = 3;

  typedef enum logic {ST_IDLE, ST_RUN} burstState_t;

  typedef struct packed {
    logic load;   // capture length, start first high phase
    logic run;    // burst active, prescaler counting
    logic abort;  // stop burst now, output low
  } burstStrobe_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pulse_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DIV_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  powerSave,
  input  logic                  lastEdge,
  output logic                  enable,
  output logic                  forceHigh,
  output logic                  busy,
  output logic [DIV_W-1:0]      divSel,
  output logic [LEN_W-1:0]      burstLen,
  output burstStrobe_t          strobe
);
  burstState_t state, stateNext;
  logic ctrlWr, startReq;

  assign ctrlWr   = wrEn && (addr == ADDR_CTRL);
  assign startReq = ctrlWr && wrData[CTRL_START] && wrData[CTRL_EN];
  assign busy     = (state == ST_RUN);

  always_comb begin
    strobe       = '0;
    strobe.run   = (state == ST_RUN);
    strobe.load  = (state == ST_IDLE) && startReq && !powerSave && (burstLen != '0);
    strobe.abort = (state == ST_RUN) && (powerSave || (ctrlWr && !wrData[CTRL_EN]));
    stateNext    = state;
    if (strobe.load) stateNext = ST_RUN;
    else if (strobe.abort || (strobe.run && lastEdge)) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      enable    <= 1'b0;
      forceHigh <= 1'b0;
      divSel    <= '0;
      burstLen  <= '0;
    end else begin
      state <= stateNext;
      if (ctrlWr) begin
        enable    <= wrData[CTRL_EN];
        forceHigh <= wrData[CTRL_FORCE];
      end
      if (wrEn && addr == ADDR_DIV) divSel <= wrData[DIV_W-1:0];
      if (wrEn && addr == ADDR_LEN) burstLen <= wrData[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pulse_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  burstStrobe_t     strobe,
  input  logic [DIV_W-1:0] divSel,
  input  logic [LEN_W-1:0] burstLen,
  output logic             phaseHi,
  output logic             lastEdge
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] preCnt, preLimit;
  logic [LEN_W-1:0] remaining;
  logic             preTerm;

  // 2^x - 1; for the widest x the shift wraps to 0 and the subtract yields all ones
  assign preLimit = (PRE_W'(1) << divSel) - PRE_W'(1);
  assign preTerm  = (preCnt == preLimit);
  assign lastEdge = strobe.run && preTerm && phaseHi && (remaining == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt    <= '0;
      phaseHi   <= 1'b0;
      remaining <= '0;
    end else if (strobe.load) begin
      preCnt    <= '0;
      phaseHi   <= 1'b1;
      remaining <= burstLen;
    end else if (strobe.abort || !strobe.run) begin
      preCnt  <= '0;
      phaseHi <= 1'b0;
    end else if (preTerm) begin
      preCnt  <= '0;
      phaseHi <= ~phaseHi;
      if (phaseHi) remaining <= remaining - LEN_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen
  import burst_pulse_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DIV_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  powerSave,
  output logic                  pulseOut
);
  burstStrobe_t     strobe;
  logic             enable, forceHigh, busy, phaseHi, lastEdge;
  logic [DIV_W-1:0] divSel;
  logic [LEN_W-1:0] burstLen;

  burst_ctrl #(.LEN_W(LEN_W), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .powerSave(powerSave), .lastEdge(lastEdge), .enable(enable),
    .forceHigh(forceHigh), .busy(busy), .divSel(divSel),
    .burstLen(burstLen), .strobe(strobe)
  );

  burst_datapath #(.LEN_W(LEN_W), .DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divSel(divSel),
    .burstLen(burstLen), .phaseHi(phaseHi), .lastEdge(lastEdge)
  );

  assign pulseOut = forceHigh || (phaseHi && busy && !powerSave);

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL: begin
        rdData[CTRL_EN]    = enable;
        rdData[CTRL_BUSY]  = busy;
        rdData[CTRL_FORCE] = forceHigh;
      end
      ADDR_DIV: rdData[DIV_W-1:0] = divSel;
      ADDR_LEN: rdData[LEN_W-1:0] = burstLen;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/burst_pulse_gen_chk.sv
module burst_pulse_gen_chk
  import burst_pulse_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWr,
  input logic             startBit,
  input logic             enBit,
  input logic             forceBit,
  input logic             powerSave,
  input logic             busy,
  input logic             forceHigh,
  input logic [LEN_W-1:0] burstLen,
  input logic             pulseOut
);
  // R3: accepted start raises busy and the output on the taking edge
  a_r3_launch: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ctrlWr && startBit && enBit && !powerSave && burstLen != '0) |=> (busy && pulseOut));

  // R6: zero length never starts a burst
  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && burstLen == '0) |=> !busy);

  // R11: power save clears busy by the next edge
  a_r11_pwr_abort: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |=> !busy);

  // R9: a control write with force set keeps the pin high next cycle
  a_r9_force: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && forceBit) |=> pulseOut);

  // R5: idle without force means a low pin
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !forceHigh) |-> !pulseOut);

  // R10: clearing enable mid-burst ends it
  a_r10_disable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWr && !enBit) |=> (!busy && !forceHigh) || (!busy && forceBit));
endmodule

bind burst_pulse_gen burst_pulse_gen_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .ctrlWr(wrEn && addr == burst_pulse_pkg::ADDR_CTRL),
  .startBit(wrData[burst_pulse_pkg::CTRL_START]),
  .enBit(wrData[burst_pulse_pkg::CTRL_EN]),
  .forceBit(wrData[burst_pulse_pkg::CTRL_FORCE]),
  .powerSave(powerSave), .busy(busy), .forceHigh(forceHigh),
  .burstLen(burstLen), .pulseOut(pulseOut)
);

// File: tb/burst_pulse_gen_tb_top.sv
module burst_pulse_gen_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       powerSave = 1'b0;
  logic       pulseOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {logic out; logic busy; string req;} expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  burst_pulse_gen dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .powerSave(powerSave), .pulseOut(pulseOut)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // control byte: bit0 enable, bit1 start, bit3 force
  function automatic logic [7:0] ctrlByte(input bit en, input bit start, input bit frc);
    return {4'd0, frc, 1'b0, start, en};
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0; addr = 2'd0; wrData = 8'd0;
  endtask

  task automatic readCheck(input logic [1:0] a, input int exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdData, exp);
    addr = 2'd0;
  endtask

  task automatic pushExp(input logic o, input logic b, input string req);
    expItem_t it;
    it.out = o; it.busy = b; it.req = req;
    expQ.push_back(it);
  endtask

  // expected schedule of a full burst, sampled one per cycle from the launch edge
  task automatic pushBurst(input int x, input int y, input bit frc);
    for (int p = 0; p < y; p++) begin
      for (int c = 0; c < (1 << x); c++) pushExp(1'b1, 1'b1, "R4");
      if (p < y - 1)
        for (int c = 0; c < (1 << x); c++) pushExp(frc, 1'b1, "R4");
    end
    for (int c = 0; c < 4; c++) pushExp(frc, 1'b0, "R5");
  endtask

  task automatic runBurst(input int x, input int y, input bit frc);
    regWrite(2'd1, 8'(x));
    regWrite(2'd2, 8'(y));
    regWrite(2'd0, ctrlByte(1'b1, 1'b1, frc));
    pushBurst(x, y, frc);
    wait (expQ.size() == 0);
  endtask

  // monitor: pops the scoreboard each cycle, busy compared while addr selects control
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      #1;
      it = expQ.pop_front();
      check({it.req, " out"}, pulseOut, it.out);
      if (addr == 2'd0) check({it.req, " busy"}, rdData[2], it.busy);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    readCheck(2'd0, 0, "R1 ctrl");
    readCheck(2'd1, 0, "R1 div");
    readCheck(2'd2, 0, "R1 len");
    check("R1 out", pulseOut, 0);

    // R2 map and readback; R8 start reads 0
    regWrite(2'd1, 8'h03);
    readCheck(2'd1, 3, "R2 div");
    regWrite(2'd2, 8'hA5);
    readCheck(2'd2, 8'hA5, "R2 len");
    readCheck(2'd3, 0, "R2 unused");
    regWrite(2'd0, 8'hF6); // busy/start/high bits set, enable clear
    readCheck(2'd0, 0, "R2 busy RO, R8 start reads 0");
    check("R10 no start when disabled", pulseOut, 0);

    // R3/R4/R5 bursts at several settings
    runBurst(0, 3, 1'b0);
    runBurst(2, 2, 1'b0);
    runBurst(1, 1, 1'b0);
    runBurst(3, 5, 1'b0);
    readCheck(2'd0, 1, "R8 start cleared after burst");

    // R6 zero length
    regWrite(2'd2, 8'd0);
    regWrite(2'd0, ctrlByte(1'b1, 1'b1, 1'b0));
    for (int c = 0; c < 6; c++) pushExp(1'b0, 1'b0, "R6");
    wait (expQ.size() == 0);

    // R7 start while busy ignored
    regWrite(2'd1, 8'd2);
    regWrite(2'd2, 8'd3);
    regWrite(2'd0, ctrlByte(1'b1, 1'b1, 1'b0));
    pushBurst(2, 3, 1'b0);
    repeat (6) @(posedge clk);
    regWrite(2'd0, ctrlByte(1'b1, 1'b1, 1'b0));
    wait (expQ.size() == 0);

    // R9 force high during a burst and idle
    runBurst(1, 2, 1'b1);
    check("R9 idle force", pulseOut, 1);
    powerSave = 1'b1;
    #1 check("R9 force over power save", pulseOut, 1);
    powerSave = 1'b0;
    regWrite(2'd0, ctrlByte(1'b0, 1'b0, 1'b0));
    @(negedge clk);
    check("R9 release", pulseOut, 0);

    // R10 disable mid burst
    regWrite(2'd1, 8'd3);
    regWrite(2'd2, 8'd4);
    regWrite(2'd0, ctrlByte(1'b1, 1'b1, 1'b0));
    repeat (2) @(posedge clk);
    regWrite(2'd0, ctrlByte(1'b0, 1'b0, 1'b0));
    @(negedge clk);
    check("R10 disabled out", pulseOut, 0);
    readCheck(2'd0, 0, "R10 busy cleared");

    // R11 power save mid burst
    regWrite(2'd0, ctrlByte(1'b1, 1'b1, 1'b0));
    repeat (2) @(posedge clk);
    @(negedge clk);
    powerSave = 1'b1;
    #1 check("R11 out low at once", pulseOut, 0);
    @(posedge clk);
    readCheck(2'd0, 1, "R11 busy cleared");
    regWrite(2'd0, ctrlByte(1'b1, 1'b1, 1'b0));
    readCheck(2'd0, 1, "R11 start ignored");
    powerSave = 1'b0;
    repeat (20) begin
      @(negedge clk);
      check("R11 stays low", pulseOut, 0);
    end

    // launch still works afterwards
    runBurst(0, 2, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule